// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block writes a frame of pixels into a display panel that keeps its own frame memory and is fed over an 8080-style parallel bus. The bus has an active-low chip select, an active-low write strobe and a data bus. Pixels come in on a valid/ready stream. Each accepted pixel becomes one write cycle on the panel bus. That cycle is built from four phase lengths, each counted in clock cycles: chip-select setup, write setup, write-strobe active and data hold.

A frame starts only when software pulses the trigger command while the interface is enabled and the bus mode is selected. No transfer ever starts by itself. The phase lengths and the frame length are captured when the frame starts. A trigger that arrives while a frame is in flight is dropped. When the last pixel of the frame has been written, a pending interrupt flag is set. It stays set until software writes a one to clear it.

Top module: `panel_wr_seq`

## Requirements
- R1: After reset, chip select and write strobe are high (inactive), `pix_ready`, `busy` and `irq` are low.
- R2: A one-cycle pulse on `trig_ctl[1]` (command) while `trig_ctl[0]` (bus mode) and `bus_cfg[0]` (enable) are 1 and the block is idle makes `busy` and `pix_ready` high in the next cycle.
- R3: A trigger pulse while `bus_cfg[0]` is 0, or while `trig_ctl[0]` is 0, has no effect: `busy` and `pix_ready` stay low.
- R4: The phase fields of `bus_cfg` are chip-select setup in bits 19:16, write setup in bits 15:12, write active in bits 11:8 and hold in bits 7:4. Chip select goes low in the cycle after a pixel is accepted and stays low for setup+wsetup+active+hold cycles. The write strobe is low for the last active+hold cycles minus hold, that is, for `active` cycles that start after setup+wsetup cycles. The write strobe is never low while chip select is high.
- R5: A write-active field of 0 gives a one-cycle strobe. Any other field of 0 removes its phase entirely.
- R6: `pix_ready` is high only while waiting for a pixel, and chip select is then high. `bus_data` holds the accepted pixel for the whole chip-select-low window. Chip select goes low only after a pixel has been accepted.
- R7: After `frame_len` pixels have been written, the block returns to idle (`busy` low) in the cycle after the last hold ends. A `frame_len` of 0 is treated as one pixel.
- R8: `irq` rises in the same cycle that `busy` falls at the end of a frame. It stays high until `irq_clr` is pulsed, and it is low in the cycle after that pulse.
- R9: A trigger pulse during a frame neither restarts nor lengthens the frame.
- R10: The phase fields and `frame_len` are sampled when the frame starts. Later changes to them do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cfg | input | 20 | Phase lengths (19:4) and interface enable (bit 0) |
| trig_ctl | input | 2 | Bit 0 selects bus mode, bit 1 is the one-shot trigger command |
| frame_len | input | CNT_W | Pixels per frame |
| irq_clr | input | 1 | Write-one pulse clearing the pending interrupt |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream data |
| pix_ready | output | 1 | Pixel stream ready |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_wr_n | output | 1 | Panel write strobe, active low |
| bus_data | output | DATA_W | Panel data bus |
| busy | output | 1 | A frame is in flight |
| irq | output | 1 | Frame-done interrupt pending |

## Verification
All results are due a fixed number of cycles after their stimulus:
- `busy` and `pix_ready` are due one cycle after the trigger edge.
- Chip select falls one cycle after the accepting edge. The strobe follows after setup plus write-setup cycles.
- `busy` falls and `irq` rises one cycle after the last hold cycle.
- The `irq_clr` effect is due one cycle after the pulse.

The bench changes inputs on the falling edge and samples on the falling edge. It walks the expected per-cycle strobe pattern, computed from the requested field values, against the outputs one falling edge at a time. No check depends on the order of processes at the rising edge.

// File: rtl/pws_pkg.sv
package pws_pkg;

  localparam int FLD_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_CSS,
    PH_WRS,
    PH_ACT,
    PH_HLD
  } phase_e;

  typedef struct packed {
    logic [FLD_W-1:0] css;
    logic [FLD_W-1:0] wrs;
    logic [FLD_W-1:0] act;
    logic [FLD_W-1:0] hld;
  } cyc_cfg_t;

  // Field positions: 19:16 cs setup, 15:12 wr setup, 11:8 active, 7:4 hold
  function automatic cyc_cfg_t unpack_cfg(input logic [19:4] w);
    cyc_cfg_t c;
    c.css = w[19:16];
    c.wrs = w[15:12];
    c.act = w[11:8];
    c.hld = w[7:4];
    return c;
  endfunction

  // Strobe phase always lasts at least one cycle
  function automatic logic [FLD_W-1:0] strobe_len(input logic [FLD_W-1:0] a);
    return (a == '0) ? FLD_W'(1) : a;
  endfunction

  // Next segment after p; PH_WAIT marks the end of a pixel write
  function automatic phase_e step_after(input phase_e p, input cyc_cfg_t c);
    phase_e n;
    case (p)
      PH_WAIT: n = (c.css != '0) ? PH_CSS : ((c.wrs != '0) ? PH_WRS : PH_ACT);
      PH_CSS:  n = (c.wrs != '0) ? PH_WRS : PH_ACT;
      PH_WRS:  n = PH_ACT;
      PH_ACT:  n = (c.hld != '0) ? PH_HLD : PH_WAIT;
      default: n = PH_WAIT;
    endcase
    return n;
  endfunction

  // Down-counter preload for a segment (length minus one)
  function automatic logic [FLD_W-1:0] seg_preload(input phase_e p, input cyc_cfg_t c);
    logic [FLD_W-1:0] v;
    case (p)
      PH_CSS:  v = c.css - 1'b1;
      PH_WRS:  v = c.wrs - 1'b1;
      PH_ACT:  v = strobe_len(c.act) - 1'b1;
      PH_HLD:  v = c.hld - 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pws_seg_timer.sv
module pws_seg_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pws_pix_counter.sv
module pws_pix_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  // Length zero falls through as a single-pixel frame
  function automatic logic reached_end(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] l);
    return ({1'b0, c} + 1'b1) >= {1'b0, l};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = reached_end(cnt, len);
endmodule

// File: rtl/pws_irq_flag.sv
module pws_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/panel_wr_seq.sv
module panel_wr_seq
  import pws_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [19:0]       bus_cfg,
  input  logic [1:0]        trig_ctl,
  input  logic [CNT_W-1:0]  frame_len,
  input  logic              irq_clr,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              irq
);
  phase_e            phase_q, phase_d, step;
  cyc_cfg_t          cfg_q;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  pix_cnt;
  logic [FLD_W-1:0]  tmr_val;
  logic              tmr_load, tmr_done, last_pix;
  logic              bus_en, mode_sel, trig_cmd;
  logic              frame_start, accept, timed, seg_end, pix_done, frame_end;
  logic [2:0]        cfg_bits_unused;

  assign bus_en          = bus_cfg[0];
  assign mode_sel        = trig_ctl[0];
  assign trig_cmd        = trig_ctl[1];
  assign cfg_bits_unused = bus_cfg[3:1];

  // Named events
  assign frame_start = (phase_q == PH_IDLE) && trig_cmd && mode_sel && bus_en;
  assign pix_ready   = (phase_q == PH_WAIT);
  assign accept      = pix_valid && pix_ready;
  assign timed       = (phase_q == PH_CSS) || (phase_q == PH_WRS) ||
                       (phase_q == PH_ACT) || (phase_q == PH_HLD);
  assign step        = step_after(phase_q, cfg_q);
  assign seg_end     = timed && tmr_done;
  assign pix_done    = seg_end && (step == PH_WAIT);
  assign frame_end   = pix_done && last_pix;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (frame_start) phase_d = PH_WAIT;
      PH_WAIT: if (accept)      phase_d = step;
      default: if (seg_end)     phase_d = pix_done ? (last_pix ? PH_IDLE : PH_WAIT) : step;
    endcase
  end

  assign tmr_load = (phase_d != phase_q);
  assign tmr_val  = seg_preload(phase_d, cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cfg_q    <= '0;
      len_q    <= '0;
      bus_data <= '0;
    end else begin
      phase_q <= phase_d;
      if (frame_start) begin
        cfg_q <= unpack_cfg(bus_cfg[19:4]);
        len_q <= frame_len;
      end
      if (accept) bus_data <= pix_data;
    end
  end

  pws_seg_timer #(.W(FLD_W)) seg_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  pws_pix_counter #(.CNT_W(CNT_W)) pix_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (frame_start),
    .inc   (pix_done),
    .len   (len_q),
    .cnt   (pix_cnt),
    .last  (last_pix)
  );

  pws_irq_flag irq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (frame_end),
    .clr   (irq_clr),
    .flag  (irq)
  );

  assign bus_cs_n = !timed;
  assign bus_wr_n = (phase_q != PH_ACT);
  assign busy     = (phase_q != PH_IDLE);

  // Strobe only inside chip select
  assert_wr_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_cs_n);

  // Waiting for a pixel keeps the bus released
  assert_ready_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> bus_cs_n);

  // A write cycle opens only after a handshake
  assert_cs_follows_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $past(pix_valid && pix_ready));

  // Pixel count never rewinds inside a frame
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (pix_cnt >= $past(pix_cnt)));

  // Interrupt pending follows the last write
  assert_irq_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (irq && !busy));
endmodule

// File: tb/panel_wr_seq_tb_top.sv
module panel_wr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [19:0]       bus_cfg = '0;
  logic [1:0]        trig_ctl = '0;
  logic [CNT_W-1:0]  frame_len = '0;
  logic              irq_clr = 1'b0;
  logic              pix_valid = 1'b0;
  logic [DATA_W-1:0] pix_data = '0;
  logic              pix_ready, bus_cs_n, bus_wr_n, busy, irq;
  logic [DATA_W-1:0] bus_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_wr_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cfg(bus_cfg), .trig_ctl(trig_ctl),
    .frame_len(frame_len), .irq_clr(irq_clr), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n), .bus_data(bus_data), .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_cfg(input int cs, input int ws,
                                         input int wa, input int wh, input bit en);
    return {4'(cs), 4'(ws), 4'(wa), 4'(wh), 3'b000, en};
  endfunction

  task automatic start_frame(input logic [19:0] cfg, input int len);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    bus_cfg = cfg; frame_len = CNT_W'(len); trig_ctl = 2'b11;
    @(negedge clk); trig_ctl = 2'b00;
    chk(busy && pix_ready && !irq, "R2", "busy&ready after trigger",
        {busy, pix_ready, irq}, 3'b110);
  endtask

  // Called at a falling edge while waiting for a pixel
  task automatic push_pixel(input logic [DATA_W-1:0] d, input int cs, input int ws,
                            input int wa, input int wh, input bit last, input bit poke);
    int a, len_l, bad, act_v, exp_v;
    a = (wa == 0) ? 1 : wa;
    len_l = cs + ws + a + wh;
    bad = 0; act_v = 0; exp_v = 0;
    pix_valid = 1'b1; pix_data = d;
    chk(pix_ready && bus_cs_n, "R6", "ready with cs high", {pix_ready, bus_cs_n}, 2'b11);
    @(negedge clk);
    pix_valid = 1'b0; pix_data = ~d;
    for (int j = 1; j <= len_l; j++) begin
      logic ew;
      ew = !((j > cs + ws) && (j <= cs + ws + a));
      if (bus_cs_n !== 1'b0 || bus_wr_n !== ew || bus_data !== d || pix_ready !== 1'b0) begin
        if (bad == 0) begin
          act_v = {bus_cs_n, bus_wr_n, pix_ready};
          exp_v = {1'b0, ew, 1'b0};
        end
        bad++;
      end
      if (poke && j == 1) trig_ctl = 2'b11;
      if (poke && j == 2) trig_ctl = 2'b00;
      @(negedge clk);
    end
    trig_ctl = 2'b00;
    chk(bad == 0, "R4/R5/R6", $sformatf("write cycle shape cycle pattern (first bad) d=%0h", d),
        act_v, exp_v);
    if (last)
      chk(bus_cs_n && !busy && irq && !pix_ready, "R7/R8", "frame end state",
          {bus_cs_n, busy, irq, pix_ready}, 4'b1010);
    else
      chk(bus_cs_n && busy && pix_ready && !irq, "R6", "back to wait",
          {bus_cs_n, busy, pix_ready, irq}, 4'b1110);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_wr_n && !pix_ready && !busy && !irq, "R1", "reset outputs",
        {bus_cs_n, bus_wr_n, pix_ready, busy, irq}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic;
    start_frame(mk_cfg(2, 1, 3, 2, 1'b1), 3);
    push_pixel(16'hA001, 2, 1, 3, 2, 1'b0, 1'b0);
    push_pixel(16'h5A02, 2, 1, 3, 2, 1'b0, 1'b0);
    push_pixel(16'hFFFF, 2, 1, 3, 2, 1'b1, 1'b0);
  endtask

  task automatic t_zero_phases;
    start_frame(mk_cfg(0, 0, 0, 0, 1'b1), 2);
    push_pixel(16'h0101, 0, 0, 0, 0, 1'b0, 1'b0);
    push_pixel(16'h0202, 0, 0, 0, 0, 1'b1, 1'b0);
    start_frame(mk_cfg(0, 3, 1, 0, 1'b1), 1);
    push_pixel(16'h0303, 0, 3, 1, 0, 1'b1, 1'b0);
    start_frame(mk_cfg(4, 0, 2, 5, 1'b1), 1);
    push_pixel(16'h0404, 4, 0, 2, 5, 1'b1, 1'b0);
  endtask

  task automatic t_disabled;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    bus_cfg = mk_cfg(1, 1, 1, 1, 1'b0); frame_len = 4; trig_ctl = 2'b11;
    @(negedge clk); trig_ctl = 2'b00;
    chk(!busy && !pix_ready, "R3", "trigger with enable off", {busy, pix_ready}, 0);
    bus_cfg = mk_cfg(1, 1, 1, 1, 1'b1); trig_ctl = 2'b10;
    @(negedge clk); trig_ctl = 2'b00;
    chk(!busy && !pix_ready && bus_cs_n, "R3", "trigger with mode off",
        {busy, pix_ready, bus_cs_n}, 3'b001);
  endtask

  task automatic t_retrigger;
    start_frame(mk_cfg(1, 1, 2, 1, 1'b1), 2);
    trig_ctl = 2'b11;
    @(negedge clk); trig_ctl = 2'b00;
    chk(busy && pix_ready, "R9", "trigger while waiting", {busy, pix_ready}, 2'b11);
    push_pixel(16'h1111, 1, 1, 2, 1, 1'b0, 1'b1);
    push_pixel(16'h2222, 1, 1, 2, 1, 1'b1, 1'b0);
    @(negedge clk);
    chk(!busy && !pix_ready, "R9", "no restart after frame", {busy, pix_ready}, 0);
  endtask

  task automatic t_irq_clear;
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R8", "irq held while idle", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R8", "irq after clear", irq, 0);
  endtask

  task automatic t_cfg_latched;
    start_frame(mk_cfg(1, 2, 3, 1, 1'b1), 2);
    bus_cfg = mk_cfg(7, 7, 7, 7, 1'b1); frame_len = 9;
    push_pixel(16'hC0DE, 1, 2, 3, 1, 1'b0, 1'b0);
    push_pixel(16'hBEEF, 1, 2, 3, 1, 1'b1, 1'b0);
    chk(!busy, "R10", "frame length sampled at start", busy, 0);
  endtask

  task automatic t_zero_len;
    start_frame(mk_cfg(1, 0, 1, 1, 1'b1), 0);
    push_pixel(16'h7777, 1, 0, 1, 1, 1'b1, 1'b0);
    chk(!busy && irq, "R7", "zero length acts as one pixel", {busy, irq}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_irq_clear();
    t_zero_phases();
    t_disabled();
    t_retrigger();
    t_cfg_latched();
    t_zero_len();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule